// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter

This block is the last digital stage of a two-channel sampling converter. It sits after the correction logic and takes one offset-binary word per channel. Each word is marked by a shared valid strobe. The block registers each word, optionally recodes it to two's complement, and presents both words on output buses. Every bus bit carries its own drive-enable bit, which stands in for a three-state pad.

Two low-power controls are also handled here. Full power-down and sleep both stop new words from entering the output registers, so the last registered word stays visible for as long as the buses are enabled. After either control is released, a strobe that stayed high across the low-power period is treated as stale. Capture resumes only once the upstream logic presents a fresh strobe, meaning the strobe has been seen low at least once while the block is awake.

Top module: `dual_adc_out_stage`

## Requirements
- R1: While reset is held and right after it, both data buses read 0, and each enable vector follows the output-disable input.
- R2: With the format input low at a capture, the registered word equals the input word. Examples: 0x3FF stays 0x3FF (top code), 0x200 stays 0x200 (mid-scale zero), and 0x000 stays 0x000 (bottom code).
- R3: With the format input high at a capture, only bit 9 of the word is inverted. So 0x3FF becomes 0x1FF, 0x200 becomes 0x000, 0x000 becomes 0x200, and 0x1FF becomes 0x3FF.
- R4: The format input is sampled together with each word. Changing it without a capture leaves the word already on the bus unchanged.
- R5: A word presented with the strobe high at a rising edge appears on its bus right after that edge. It stays there until the next capture.
- R6: While the strobe is low, both buses hold their value whatever the sample inputs do.
- R7: With the output-disable input high, every enable bit of both buses is 0. With it low, every enable bit is 1. The change follows the input within the same cycle.
- R8: The output-disable input does not affect the registers. Words captured while the buses are disabled are shown when the buses are enabled again.
- R9: While power-down is high, both buses keep their last word, even when strobed words arrive.
- R10: While sleep is high, both buses keep their last word, even when strobed words arrive.
- R11: After power-down or sleep falls, a strobe that stays high is not captured. The first capture is a strobe that rises after the strobe was seen low while awake.
- R12: Channel A and channel B are registered independently, each from its own input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_vld | input | 1 | Strobe marking a new word on both sample inputs |
| samp_a | input | 10 | Channel A offset-binary word |
| samp_b | input | 10 | Channel B offset-binary word |
| fmt_twos | input | 1 | 1 = two's complement output, 0 = offset binary |
| out_dis | input | 1 | 1 = both buses released (high impedance) |
| pwr_down | input | 1 | Full power-down; freezes the output registers |
| conv_sleep | input | 1 | Sleep; stops new words, freezes the output registers |
| dout_a | output | 10 | Channel A output bus value |
| dout_b | output | 10 | Channel B output bus value |
| dout_oe_a | output | 10 | Per-bit drive enable for channel A |
| dout_oe_b | output | 10 | Per-bit drive enable for channel B |

## Verification
A wrong format bit shows up as a flipped top bit on the next bus word. The zero and full-scale codes expose that error at once. A faulty capture gate, such as a power-down or sleep that leaks words or a stale-strobe flag that never clears, shows up as a bus that changes, or fails to change, one edge after the strobe. Enable faults appear in the same cycle the disable input moves. A disable that wrongly clears the register only shows up when the buses are enabled again.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;

    // Capture-gate state: stale marks a strobe that has not dropped since wake-up
    typedef struct packed {
        logic stale;
    } gate_st_t;

endpackage

// File: rtl/adcfmt_gate.sv
module adcfmt_gate
    import adcfmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic samp_vld,
    input  logic pwr_down,
    input  logic conv_sleep,
    output logic cap_en
);

    gate_st_t st_d, st_q;
    logic     asleep;

    always_comb begin
        asleep   = pwr_down | conv_sleep;
        st_d     = st_q;
        if (asleep) begin
            st_d.stale = 1'b1;
        end else if (!samp_vld) begin
            st_d.stale = 1'b0;
        end
        cap_en   = samp_vld & ~asleep & ~st_q.stale;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/adcfmt_chan.sv
module adcfmt_chan #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          fmt_twos,
    input  logic [DW-1:0] samp,
    output logic [DW-1:0] word
);

    typedef struct packed {
        logic [DW-1:0] word;
    } chan_st_t;

    chan_st_t      st_d, st_q;
    logic [DW-1:0] coded;

    always_comb begin
        // offset binary -> two's complement: invert the sign position only
        coded = {samp[DW-1] ^ fmt_twos, samp[DW-2:0]};
        st_d  = st_q;
        if (cap_en) begin
            st_d.word = coded;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;

endmodule

// File: rtl/adcfmt_drv.sv
module adcfmt_drv #(
    parameter int DW = 10
) (
    input  logic          out_dis,
    input  logic [DW-1:0] word,
    output logic [DW-1:0] bus,
    output logic [DW-1:0] bus_oe
);

    always_comb begin
        bus    = word;
        bus_oe = {DW{~out_dis}};
    end

endmodule

// File: rtl/dual_adc_out_stage.sv
module dual_adc_out_stage #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          samp_vld,
    input  logic [DW-1:0] samp_a,
    input  logic [DW-1:0] samp_b,
    input  logic          fmt_twos,
    input  logic          out_dis,
    input  logic          pwr_down,
    input  logic          conv_sleep,
    output logic [DW-1:0] dout_a,
    output logic [DW-1:0] dout_b,
    output logic [DW-1:0] dout_oe_a,
    output logic [DW-1:0] dout_oe_b
);

    localparam int NCH = 2;

    logic                    cap_en;
    logic [NCH-1:0][DW-1:0]  samp_arr;
    logic [NCH-1:0][DW-1:0]  word_arr;
    logic [NCH-1:0][DW-1:0]  bus_arr;
    logic [NCH-1:0][DW-1:0]  oe_arr;

    assign samp_arr = {samp_b, samp_a};

    adcfmt_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_vld   (samp_vld),
        .pwr_down   (pwr_down),
        .conv_sleep (conv_sleep),
        .cap_en     (cap_en)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        adcfmt_chan #(.DW(DW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_en   (cap_en),
            .fmt_twos (fmt_twos),
            .samp     (samp_arr[ch]),
            .word     (word_arr[ch])
        );
        adcfmt_drv #(.DW(DW)) u_drv (
            .out_dis (out_dis),
            .word    (word_arr[ch]),
            .bus     (bus_arr[ch]),
            .bus_oe  (oe_arr[ch])
        );
    end

    assign dout_a    = bus_arr[0];
    assign dout_b    = bus_arr[1];
    assign dout_oe_a = oe_arr[0];
    assign dout_oe_b = oe_arr[1];

endmodule

// File: rtl/adcfmt_out_chk.sv
module adcfmt_out_chk #(
    parameter int DW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          samp_vld,
    input logic [DW-1:0] samp_a,
    input logic [DW-1:0] samp_b,
    input logic          fmt_twos,
    input logic          out_dis,
    input logic          pwr_down,
    input logic          conv_sleep,
    input logic [DW-1:0] dout_a,
    input logic [DW-1:0] dout_b,
    input logic [DW-1:0] dout_oe_a,
    input logic [DW-1:0] dout_oe_b
);

    p_hold_novld_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_vld |=> ($stable(dout_a) && $stable(dout_b)));

    p_pd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> ($stable(dout_a) && $stable(dout_b)));

    p_sleep_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        conv_sleep |=> ($stable(dout_a) && $stable(dout_b)));

    p_oe_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis |-> (dout_oe_a == '0 && dout_oe_b == '0));

    p_oe_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_dis |-> (dout_oe_a == '1 && dout_oe_b == '1));

    p_map_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout_a) |->
            dout_a == ($past(samp_a) ^ {$past(fmt_twos), {(DW-1){1'b0}}}));

    p_map_b_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout_b) |->
            dout_b == ($past(samp_b) ^ {$past(fmt_twos), {(DW-1){1'b0}}}));

    p_chg_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dout_a) || !$stable(dout_b)) |->
            ($past(samp_vld) && !$past(pwr_down) && !$past(conv_sleep)));

endmodule

bind dual_adc_out_stage adcfmt_out_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_vld   (samp_vld),
    .samp_a     (samp_a),
    .samp_b     (samp_b),
    .fmt_twos   (fmt_twos),
    .out_dis    (out_dis),
    .pwr_down   (pwr_down),
    .conv_sleep (conv_sleep),
    .dout_a     (dout_a),
    .dout_b     (dout_b),
    .dout_oe_a  (dout_oe_a),
    .dout_oe_b  (dout_oe_b)
);

// File: tb/dual_adc_out_stage_tb.sv
module dual_adc_out_stage_tb;

    localparam int DW      = 10;
    localparam int CLK_PER = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          samp_vld;
    logic [DW-1:0] samp_a, samp_b;
    logic          fmt_twos, out_dis, pwr_down, conv_sleep;
    logic [DW-1:0] dout_a, dout_b, dout_oe_a, dout_oe_b;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PER/2) clk = ~clk;

    dual_adc_out_stage #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld),
        .samp_a(samp_a), .samp_b(samp_b), .fmt_twos(fmt_twos),
        .out_dis(out_dis), .pwr_down(pwr_down), .conv_sleep(conv_sleep),
        .dout_a(dout_a), .dout_b(dout_b),
        .dout_oe_a(dout_oe_a), .dout_oe_b(dout_oe_b)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
        end
    endtask

    // one clock, then settle away from the edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic f);
        samp_a = a; samp_b = b; fmt_twos = f; samp_vld = 1'b1;
        tick();
        samp_vld = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset a", dout_a, '0);
        chk("R1 reset b", dout_b, '0);
        chk("R1 reset oe", dout_oe_a, '1);
    endtask

    task automatic t_offset();
        push(10'h3FF, 10'h000, 1'b0);
        chk("R2 top code a", dout_a, 10'h3FF);
        chk("R12 bottom code b", dout_b, 10'h000);
        push(10'h200, 10'h1FF, 1'b0);
        chk("R2 mid zero a", dout_a, 10'h200);
        chk("R5 latency b", dout_b, 10'h1FF);
    endtask

    task automatic t_twos();
        push(10'h3FF, 10'h000, 1'b1);
        chk("R3 top a", dout_a, 10'h1FF);
        chk("R3 bottom b", dout_b, 10'h200);
        push(10'h200, 10'h1FF, 1'b1);
        chk("R3 zero a", dout_a, 10'h000);
        chk("R3 below zero b", dout_b, 10'h3FF);
    endtask

    task automatic t_fmt_switch();
        push(10'h200, 10'h2AB, 1'b0);
        fmt_twos = 1'b1;
        tick();
        chk("R4 fmt change no capture", dout_a, 10'h200);
        push(10'h200, 10'h2AB, 1'b1);
        chk("R4 fmt next word a", dout_a, 10'h000);
        chk("R4 fmt next word b", dout_b, 10'h0AB);
    endtask

    task automatic t_hold();
        push(10'h123, 10'h321, 1'b0);
        samp_a = 10'h0F0; samp_b = 10'h00F;
        tick(); tick(); tick();
        chk("R6 hold a", dout_a, 10'h123);
        chk("R6 hold b", dout_b, 10'h321);
    endtask

    task automatic t_oe();
        out_dis = 1'b1;
        #1;
        chk("R7 oe off a", dout_oe_a, '0);
        chk("R7 oe off b", dout_oe_b, '0);
        push(10'h155, 10'h0AA, 1'b0);
        out_dis = 1'b0;
        #1;
        chk("R7 oe on b", dout_oe_b, '1);
        chk("R8 captured while off a", dout_a, 10'h155);
        chk("R8 captured while off b", dout_b, 10'h0AA);
    endtask

    task automatic t_pd();
        push(10'h111, 10'h222, 1'b0);
        pwr_down = 1'b1;
        push(10'h333, 10'h044, 1'b0);
        push(10'h055, 10'h066, 1'b1);
        chk("R9 pd hold a", dout_a, 10'h111);
        chk("R9 pd hold b", dout_b, 10'h222);
        out_dis = 1'b1;
        #1;
        chk("R9 pd with oe off", dout_oe_a, '0);
        out_dis = 1'b0;
        pwr_down = 1'b0;
        tick();
        push(10'h077, 10'h088, 1'b0);
        chk("R9 resume a", dout_a, 10'h077);
    endtask

    task automatic t_sleep();
        conv_sleep = 1'b1;
        push(10'h300, 10'h0C0, 1'b0);
        tick();
        chk("R10 sleep hold a", dout_a, 10'h077);
        chk("R10 sleep hold b", dout_b, 10'h088);
        conv_sleep = 1'b0;
        tick();
        push(10'h300, 10'h0C0, 1'b0);
        chk("R10 resume b", dout_b, 10'h0C0);
    endtask

    task automatic t_stale();
        pwr_down = 1'b1;
        samp_a = 10'h2DD; samp_b = 10'h1EE; fmt_twos = 1'b0; samp_vld = 1'b1;
        tick();
        pwr_down = 1'b0;
        tick(); tick();
        chk("R11 stale strobe a", dout_a, 10'h300);
        samp_vld = 1'b0;
        tick();
        chk("R11 still held", dout_b, 10'h0C0);
        push(10'h2DD, 10'h1EE, 1'b0);
        chk("R11 fresh strobe a", dout_a, 10'h2DD);
        chk("R11 fresh strobe b", dout_b, 10'h1EE);
        conv_sleep = 1'b1; samp_vld = 1'b1; samp_a = 10'h001;
        tick();
        conv_sleep = 1'b0;
        tick();
        chk("R11 stale after sleep", dout_a, 10'h2DD);
        samp_vld = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; samp_vld = 1'b0; samp_a = '0; samp_b = '0;
        fmt_twos = 1'b0; out_dis = 1'b0; pwr_down = 1'b0; conv_sleep = 1'b0;
        #(CLK_PER*3 + 2);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_offset();
        t_twos();
        t_fmt_switch();
        t_hold();
        t_oe();
        t_pd();
        t_sleep();
        t_stale();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule